// File: doc/BRIEF.md
# Inverter Fault and Lockout Controller

This block watches over a three-phase gate-drive stage. Each cycle it decides whether the six drive outputs must be forced off, either as a group or one high side at a time. All of its inputs are clean digital flags. It reads:

- a logic-supply undervoltage flag;
- three high-side supply undervoltage flags;
- an over-current trip input;
- three per-phase negative-transient flags;
- the active-low high-side and low-side commands of each phase.

It produces a global disable and three per-phase high-side disables. It also produces a fault indication, given as an active-low level plus an output enable, so that a pad can model an open-drain pin.

An over-current trip must persist for a blanking window before it is acted on. Once qualified, the trip is held in a latch until the trip input is low and every low-side command is idle. A logic-supply undervoltage turns everything off only while it lasts. A high-side supply fault, or a long negative transient on a phase, affects only that phase's high side. After a supply fault, the high side comes back only when its command is asserted afresh. All intervals are counted in clock cycles.

Top module: `inv_fault_ctrl`

## Requirements
- R1: While `rst` is high, and after reset until a clock edge samples `lv_uv` low, `all_off`=1, `hs_off`=3'b111 and `fault_n`=0. The trip latch is clear and no phase is armed.
- R2: When `oc_trip` is sampled high on BLANK_CYC consecutive edges, the trip latch sets at the last of those edges. From then on `all_off`=1, `hs_off`=3'b111 and `fault_n`=0.
- R3: An `oc_trip` pulse of fewer than BLANK_CYC consecutive high samples has no effect on any output, and it restarts the blanking count.
- R4: The trip latch stays set after `oc_trip` falls, for as long as any bit of `lo_cmd_n` is 0. It clears at the first edge that samples `oc_trip`=0 together with `lo_cmd_n`=3'b111. Each phase's armed state is kept across the trip.
- R5: A sampled `lv_uv`=1 forces `all_off`=1 and `fault_n`=0 after that edge. This fault is not latched: the outputs are released after the first edge that samples `lv_uv`=0, unless the trip latch is set.
- R6: A sampled `hs_uv[i]`=1 sets `hs_off[i]`=1 after that edge. It leaves `fault_n` and the other phases unchanged.
- R7: A phase is armed only by a falling edge of `hi_cmd_n[i]` (sampled 1 on one edge, 0 on the next) while `hs_uv[i]`=0. A `hs_uv[i]` sampled on the same edge wins, and the phase stays disarmed. Until the phase is armed again, `hs_off[i]`=1.
- R8: When `neg_tr[i]` is sampled high on NEG_QUAL_CYC+1 consecutive edges, `hs_off[i]`=1 for exactly NEG_HOLD_CYC cycles, starting after the last of those edges. This happens once per high episode. Shorter episodes have no effect.
- R9: `fault_oe` is 1 exactly when `fault_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lv_uv | input | 1 | Logic-supply undervoltage flag, active high |
| hs_uv | input | 3 | Per-phase high-side supply undervoltage flags |
| oc_trip | input | 1 | Over-current trip input, active high |
| lo_cmd_n | input | 3 | Low-side commands, active low |
| hi_cmd_n | input | 3 | High-side commands, active low |
| neg_tr | input | 3 | Per-phase negative-transient flags |
| all_off | output | 1 | Global disable for all six drivers |
| hs_off | output | 3 | Per-phase high-side disable |
| fault_n | output | 1 | Fault indication, active low |
| fault_oe | output | 1 | Drive enable for the fault pin (open-drain model) |

## Verification
Two functions can act on one phase in the same cycle. The re-arm edge detector can see a fresh command assertion on the very edge where that phase's supply flag rises. The bench provokes this by lowering `hi_cmd_n[1]` together with `hs_uv[1]`. It then expects `hs_off[1]` to stay 1, both then and after the flag clears while the command is still held, and to drop only on a later, separate falling edge. In a second overlap, a trip latches while the low-side commands are already idle. The latch must hold until `oc_trip` itself is sampled low.

// File: rtl/iflc_pkg.sv
package iflc_pkg;
    localparam int NPH = 3;

    function automatic int cnt_w(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

    typedef struct packed {
        logic           all_off;
        logic [NPH-1:0] hs_off;
        logic           fault_n;
    } drive_ctl_t;
endpackage

// File: rtl/ifc_persist.sv
module ifc_persist #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);
    import iflc_pkg::*;
    localparam int W = cnt_w(LEN);

    logic [W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !din)
            run_q <= '0;
        else if (run_q != W'(LEN))
            run_q <= run_q + 1'b1;
    end

    assign hit = din && (run_q == W'(LEN - 1));
endmodule

// File: rtl/ifc_trip_latch.sv
module ifc_trip_latch #(
    parameter int BLANK_CYC = 80
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     oc_trip,
    input  logic [iflc_pkg::NPH-1:0] lo_cmd_n,
    output logic                     tripped
);
    logic hit;
    logic lo_idle;

    ifc_persist #(.LEN(BLANK_CYC)) blank_i (
        .clk(clk), .rst(rst), .din(oc_trip), .hit(hit)
    );

    assign lo_idle = &lo_cmd_n;

    always_ff @(posedge clk) begin
        if (rst)
            tripped <= 1'b0;
        else if (hit)
            tripped <= 1'b1;
        else if (!oc_trip && lo_idle)
            tripped <= 1'b0;
    end

    p_trip_set_r2: assert property (@(posedge clk) disable iff (rst)
        hit |=> tripped);
    p_trip_clear_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(tripped) |-> $past(!oc_trip && lo_idle));
endmodule

// File: rtl/ifc_hs_gate.sv
module ifc_hs_gate #(
    parameter int NEG_QUAL_CYC = 10,
    parameter int NEG_HOLD_CYC = 900
) (
    input  logic clk,
    input  logic rst,
    input  logic uv,
    input  logic cmd_n,
    input  logic neg,
    input  logic all_off,
    output logic hs_off
);
    import iflc_pkg::*;
    localparam int HW = cnt_w(NEG_HOLD_CYC);

    logic          armed;
    logic          cmd_prev;
    logic          fall;
    logic          neg_start;
    logic [HW-1:0] hold_q;
    logic          hold_act;

    ifc_persist #(.LEN(NEG_QUAL_CYC + 1)) qual_i (
        .clk(clk), .rst(rst), .din(neg), .hit(neg_start)
    );

    assign fall = cmd_prev && !cmd_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_prev <= 1'b0;
            armed    <= 1'b0;
        end else begin
            cmd_prev <= cmd_n;
            if (uv)
                armed <= 1'b0;
            else if (fall)
                armed <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (neg_start)
            hold_q <= HW'(NEG_HOLD_CYC);
        else if (hold_q != '0)
            hold_q <= hold_q - 1'b1;
    end

    assign hold_act = (hold_q != '0);
    assign hs_off   = all_off || !armed || hold_act;

    p_uv_disarm_r6: assert property (@(posedge clk) disable iff (rst)
        uv |=> hs_off);
    p_rearm_edge_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(fall && !uv));
    p_neg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        neg_start |=> hs_off);
endmodule

// File: rtl/inv_fault_ctrl.sv
module inv_fault_ctrl #(
    parameter int BLANK_CYC    = 80,
    parameter int NEG_QUAL_CYC = 10,
    parameter int NEG_HOLD_CYC = 900
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     lv_uv,
    input  logic [iflc_pkg::NPH-1:0] hs_uv,
    input  logic                     oc_trip,
    input  logic [iflc_pkg::NPH-1:0] lo_cmd_n,
    input  logic [iflc_pkg::NPH-1:0] hi_cmd_n,
    input  logic [iflc_pkg::NPH-1:0] neg_tr,
    output logic                     all_off,
    output logic [iflc_pkg::NPH-1:0] hs_off,
    output logic                     fault_n,
    output logic                     fault_oe
);
    import iflc_pkg::*;

    logic       lv_q;
    logic       tripped;
    drive_ctl_t ctl;

    always_ff @(posedge clk) begin
        if (rst)
            lv_q <= 1'b1;
        else
            lv_q <= lv_uv;
    end

    ifc_trip_latch #(.BLANK_CYC(BLANK_CYC)) trip_i (
        .clk(clk), .rst(rst), .oc_trip(oc_trip),
        .lo_cmd_n(lo_cmd_n), .tripped(tripped)
    );

    assign ctl.all_off = tripped || lv_q;
    assign ctl.fault_n = !(tripped || lv_q);

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        ifc_hs_gate #(
            .NEG_QUAL_CYC(NEG_QUAL_CYC),
            .NEG_HOLD_CYC(NEG_HOLD_CYC)
        ) hs_i (
            .clk(clk), .rst(rst), .uv(hs_uv[p]), .cmd_n(hi_cmd_n[p]),
            .neg(neg_tr[p]), .all_off(ctl.all_off), .hs_off(ctl.hs_off[p])
        );
    end

    assign all_off  = ctl.all_off;
    assign hs_off   = ctl.hs_off;
    assign fault_n  = ctl.fault_n;
    assign fault_oe = !ctl.fault_n;

    p_lv_off_r5: assert property (@(posedge clk) disable iff (rst)
        lv_uv |=> (all_off && !fault_n));
    p_off_all_r1: assert property (@(posedge clk) disable iff (rst)
        all_off |-> (&hs_off));
endmodule

// File: tb/inv_fault_ctrl_tb_top.sv
module inv_fault_ctrl_tb_top;
    localparam int BL = 8;
    localparam int NQ = 3;
    localparam int NH = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lv_uv = 1'b1;
    logic [2:0] hs_uv = 3'b000;
    logic       oc_trip = 1'b0;
    logic [2:0] lo_cmd_n = 3'b111;
    logic [2:0] hi_cmd_n = 3'b111;
    logic [2:0] neg_tr = 3'b000;
    logic       all_off;
    logic [2:0] hs_off;
    logic       fault_n;
    logic       fault_oe;

    typedef struct {
        logic       a_off;
        logic [2:0] h_off;
        logic       f_n;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    always #2.5 clk = ~clk;

    inv_fault_ctrl #(.BLANK_CYC(BL), .NEG_QUAL_CYC(NQ), .NEG_HOLD_CYC(NH)) dut_i (
        .clk(clk), .rst(rst), .lv_uv(lv_uv), .hs_uv(hs_uv), .oc_trip(oc_trip),
        .lo_cmd_n(lo_cmd_n), .hi_cmd_n(hi_cmd_n), .neg_tr(neg_tr),
        .all_off(all_off), .hs_off(hs_off), .fault_n(fault_n), .fault_oe(fault_oe)
    );

    // monitor: compares one expected item per clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (all_off !== e.a_off || hs_off !== e.h_off || fault_n !== e.f_n
                || fault_oe !== !e.f_n) begin
                n_bad++;
                $display("FAIL %s: got off=%b hs=%b fn=%b oe=%b exp off=%b hs=%b fn=%b oe=%b",
                         e.tag, all_off, hs_off, fault_n, fault_oe,
                         e.a_off, e.h_off, e.f_n, !e.f_n);
            end
        end
    end

    task automatic expect_nx(input logic a, input logic [2:0] h, input logic f, input string t);
        exp_t e;
        e.a_off = a; e.h_off = h; e.f_n = f; e.tag = t;
        q.push_back(e);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        expect_nx(1, 3'b111, 0, "R1 reset state R9");
        rst = 1'b0;
        expect_nx(1, 3'b111, 0, "R1 held while lv_uv");
        lv_uv = 1'b0;
        expect_nx(0, 3'b111, 1, "R1 enable, phases unarmed");
        hi_cmd_n = 3'b000;
        expect_nx(0, 3'b000, 1, "R7 arm on fall");
        hi_cmd_n = 3'b111;
        expect_nx(0, 3'b000, 1, "R7 stays armed");

        // short trip pulse
        oc_trip = 1'b1;
        for (int k = 0; k < BL - 1; k++) expect_nx(0, 3'b000, 1, "R3 short trip ignored");
        oc_trip = 1'b0;
        expect_nx(0, 3'b000, 1, "R3 after short trip");
        // qualified trip
        oc_trip = 1'b1;
        for (int k = 0; k < BL - 1; k++) expect_nx(0, 3'b000, 1, "R3 blanking restarted");
        expect_nx(1, 3'b111, 0, "R2 trip latched");
        expect_nx(1, 3'b111, 0, "R4 trip still high, lo idle");
        oc_trip = 1'b0;
        lo_cmd_n = 3'b110;
        expect_nx(1, 3'b111, 0, "R4 latched with lo active");
        expect_nx(1, 3'b111, 0, "R4 latched with lo active 2");
        lo_cmd_n = 3'b111;
        expect_nx(0, 3'b000, 1, "R4 cleared, arming kept");

        // logic supply fault, not latched
        lv_uv = 1'b1;
        expect_nx(1, 3'b111, 0, "R5 lv fault");
        lv_uv = 1'b0;
        expect_nx(0, 3'b000, 1, "R5 lv release");

        // high-side supply and re-arm
        hs_uv = 3'b010;
        expect_nx(0, 3'b010, 1, "R6 hs uv one phase, no fault");
        hs_uv = 3'b000;
        expect_nx(0, 3'b010, 1, "R7 no rearm without edge");
        hi_cmd_n = 3'b101;
        hs_uv = 3'b010;
        expect_nx(0, 3'b010, 1, "R7 uv beats edge");
        hs_uv = 3'b000;
        expect_nx(0, 3'b010, 1, "R7 held cmd no edge");
        hi_cmd_n = 3'b111;
        expect_nx(0, 3'b010, 1, "R7 cmd released");
        hi_cmd_n = 3'b101;
        expect_nx(0, 3'b000, 1, "R7 fresh edge rearms");
        hi_cmd_n = 3'b111;
        expect_nx(0, 3'b000, 1, "R7 remains armed");

        // negative transient
        neg_tr = 3'b100;
        for (int k = 0; k < NQ; k++) expect_nx(0, 3'b000, 1, "R8 short transient ignored");
        neg_tr = 3'b000;
        expect_nx(0, 3'b000, 1, "R8 after short transient");
        neg_tr = 3'b100;
        for (int k = 0; k < NQ; k++) expect_nx(0, 3'b000, 1, "R8 qualifying");
        expect_nx(0, 3'b100, 1, "R8 hold start");
        neg_tr = 3'b000;
        for (int k = 1; k < NH; k++) expect_nx(0, 3'b100, 1, "R8 hold active");
        expect_nx(0, 3'b000, 1, "R8 hold ended");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule